// File: doc/BRIEF.md
# Host Bus Strobe Wait-State Timer

This block times the data-phase strobes of an external host-bus access for a single chip select. When an access starts, it drives exactly one active-low strobe, the read/output-enable strobe or the write strobe, for a number of clocks. That count comes from a small wait-state code, a trim bit that removes one clock, a burst flag and a per-chip-select timing enable. The address phase is produced by other logic and is not touched here. This block only decides how long the data-phase strobe stays low and when it returns high.

The strobe length is captured when an access is accepted, so the configuration inputs may change at any time without disturbing an access already in flight. A one-clock done pulse marks the cycle in which the strobe returns high. A new access may be accepted in that same cycle, which gives back-to-back strobes separated by one high cycle.

Top module: `hb_strobe_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it, both strobes are high and done is low. Reset is synchronous and active low.
- R2: A start sampled high at a clock edge while no strobe is active begins an access. From the next cycle, the write strobe goes low if the direction input is 1, or the read strobe goes low if it is 0. The other strobe stays high, and the two strobes are never low together.
- R3: With timing enabled, burst off and trim clear, a read with code c (0 to 3) holds the read strobe low for 2*(c+1) consecutive clocks, giving 2, 4, 6 or 8 clocks.
- R4: With timing enabled, burst off and trim clear, a write with code c holds the write strobe low for 2*(c+1) consecutive clocks.
- R5: When the trim bit for the access direction is set, the strobe is one clock shorter than it would otherwise be. The other direction's trim bit has no effect.
- R6: With burst set, the wait-state codes are ignored. The strobe lasts 2 clocks, or 1 clock with the direction's trim bit set.
- R7: With the timing enable clear, the wait-state codes are ignored. The strobe lasts 2 clocks, or 1 clock with the direction's trim bit set.
- R8: Length and direction are fixed when the access is accepted. Changing the codes, trim bits, burst, enable or direction during the access does not alter it.
- R9: Done is high for exactly one clock, in the first cycle in which the strobe is high again after an access.
- R10: A start that is high while a strobe is active is ignored and neither restarts nor extends the access.
- R11: A start held high in the done cycle is accepted. The next strobe goes low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Access start request |
| is_write_i | input | 1 | Direction: 1 = write, 0 = read |
| burst_i | input | 1 | Burst mode; wait-state codes ignored |
| cs_timing_en_i | input | 1 | Per-chip-select timing enable |
| rd_ws_i | input | 2 | Read wait-state code |
| wr_ws_i | input | 2 | Write wait-state code |
| rd_trim_i | input | 1 | Shorten read strobe by one clock |
| wr_trim_i | input | 1 | Shorten write strobe by one clock |
| rd_n_o | output | 1 | Read / output-enable strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-clock pulse when the strobe deasserts |

## Verification
The bench targets the boundary lengths. The largest code gives the 8-clock strobe; a design that truncated the counter would release it early. A trimmed minimum gives a 1-clock strobe; an off-by-one reload would stretch it to 2 clocks or wrap the counter to a long strobe. The bench changes codes, trim, burst and even direction in the middle of an access, which exposes any design that reads the live configuration instead of the captured one. It also holds start high across whole accesses: a design that re-armed while busy would lengthen the strobe, and one that refused a start in the done cycle would leave an extra idle gap between back-to-back strobes.

// File: rtl/hbs_pkg.sv
// Package: shared types for the host bus strobe timer.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package hbs_pkg;

    // Direction of an access, also the index into per-direction arrays.
    typedef enum logic {
        HBS_DIR_RD = 1'b0,
        HBS_DIR_WR = 1'b1
    } hbs_dir_e;

    // Number of strobe directions handled by the timer.
    localparam int unsigned HBS_NUM_DIR = 2;

endpackage

// File: rtl/hbs_len_decode.sv
// Module: hbs_len_decode
// Turns a wait-state code and trim bit into a strobe length in clocks.
// Assumes STEP_CLKS >= 2 so a trimmed length never reaches zero.
// Purely combinational; the caller captures the result at access start.
module hbs_len_decode #(
    parameter int unsigned CODE_W    = 2,
    parameter int unsigned STEP_CLKS = 2,
    parameter int unsigned LEN_W     = 4
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              use_code_i,
    input  logic              trim_i,
    output logic [LEN_W-1:0]  len_o
);

    logic [LEN_W-1:0] steps;
    logic [LEN_W-1:0] full_len;

    // Number of 2-clock steps: code+1 when codes apply, else one step.
    always_comb begin
        if (use_code_i) begin
            steps = LEN_W'(code_i) + LEN_W'(1);
        end else begin
            steps = LEN_W'(1);
        end
    end

    // Scale steps to clocks, then apply the one-clock trim.
    always_comb begin
        full_len = steps * LEN_W'(STEP_CLKS);
        len_o    = trim_i ? (full_len - LEN_W'(1)) : full_len;
    end

    // Length must never be zero, otherwise no strobe would be produced.
    always_comb begin
        if (!$isunknown(len_o)) begin
            AST_LEN_NONZERO: assert (len_o != '0); // R5
        end
    end

endmodule

// File: rtl/hbs_strobe_seq.sv
// Module: hbs_strobe_seq
// Runs one data-phase strobe: accepts a start when idle, drives the
// chosen active-low strobe for len_i clocks, then pulses done.
// Assumes len_i >= 1 whenever start_i may be accepted.
module hbs_strobe_seq #(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic             done_o,
    output logic             busy_o
);

    import hbs_pkg::*;

    logic [LEN_W-1:0] cnt_q;
    logic             rd_n_q;
    logic             wr_n_q;
    logic             done_q;
    logic             accept;
    logic             release_now;

    // An access is in flight while either strobe is low.
    assign busy_o      = !rd_n_q || !wr_n_q;
    assign accept      = !busy_o && start_i;
    assign release_now = busy_o && (cnt_q == '0);

    // Remaining-clock counter: load on accept, count down while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= len_i - LEN_W'(1);
        end else if (busy_o && !release_now) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // Strobe registers: drive one low on accept, both high on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
        end else if (accept) begin
            rd_n_q <= (hbs_dir_e'(is_write_i) == HBS_DIR_WR);
            wr_n_q <= (hbs_dir_e'(is_write_i) == HBS_DIR_RD);
        end else if (release_now) begin
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
        end
    end

    // Done pulse: high for the one cycle in which the strobe returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= release_now;
        end
    end

    assign rd_n_o = rd_n_q;
    assign wr_n_o = wr_n_q;
    assign done_o = done_q;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (rd_n_q && wr_n_q && !done_q)); // R1

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_q && !wr_n_q)); // R2

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rd_n_q && wr_n_q && $past(busy_o))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R9

    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - LEN_W'(1))); // R10

endmodule

// File: rtl/hb_strobe_timer.sv
// Module: hb_strobe_timer (top)
// Data-phase strobe timer for one chip select. It decodes a length per
// direction from the wait-state code, trim, burst and enable inputs, then
// hands the selected length to the strobe sequencer at access start.
// Assumes the address phase is sequenced elsewhere.
module hb_strobe_timer #(
    parameter int unsigned CODE_W    = 2,
    parameter int unsigned STEP_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic              burst_i,
    input  logic              cs_timing_en_i,
    input  logic [CODE_W-1:0] rd_ws_i,
    input  logic [CODE_W-1:0] wr_ws_i,
    input  logic              rd_trim_i,
    input  logic              wr_trim_i,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              done_o
);

    import hbs_pkg::*;

    localparam int unsigned MAX_LEN = STEP_CLKS * (2 ** CODE_W);
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    logic [CODE_W-1:0] code_arr [HBS_NUM_DIR];
    logic              trim_arr [HBS_NUM_DIR];
    logic [LEN_W-1:0]  len_arr  [HBS_NUM_DIR];
    logic [LEN_W-1:0]  len_sel;
    logic              use_code;
    logic              busy;

    // Codes apply only with the timing enable set and burst off.
    assign use_code = cs_timing_en_i && !burst_i;

    // Gather per-direction configuration into arrays indexed by direction.
    always_comb begin
        code_arr[HBS_DIR_RD] = rd_ws_i;
        code_arr[HBS_DIR_WR] = wr_ws_i;
        trim_arr[HBS_DIR_RD] = rd_trim_i;
        trim_arr[HBS_DIR_WR] = wr_trim_i;
    end

    // One length decoder per direction.
    for (genvar d = 0; d < HBS_NUM_DIR; d++) begin : g_dir
        hbs_len_decode #(
            .CODE_W    (CODE_W),
            .STEP_CLKS (STEP_CLKS),
            .LEN_W     (LEN_W)
        ) u_len (
            .code_i     (code_arr[d]),
            .use_code_i (use_code),
            .trim_i     (trim_arr[d]),
            .len_o      (len_arr[d])
        );
    end

    // Pick the length for the requested direction.
    assign len_sel = is_write_i ? len_arr[HBS_DIR_WR] : len_arr[HBS_DIR_RD];

    hbs_strobe_seq #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .is_write_i (is_write_i),
        .len_i      (len_sel),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o),
        .done_o     (done_o),
        .busy_o     (busy)
    );

    AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i && is_write_i) |=> (!wr_n_o && rd_n_o)); // R2

    AST_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i && !is_write_i) |=> (!rd_n_o && wr_n_o)); // R2

    AST_DONE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> busy); // R11

endmodule

// File: tb/hb_strobe_timer_bench.sv
module hb_strobe_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       is_wr = 1'b0;
    logic       burst = 1'b0;
    logic       en = 1'b1;
    logic [1:0] rd_ws = 2'd0;
    logic [1:0] wr_ws = 2'd0;
    logic       rd_trim = 1'b0;
    logic       wr_trim = 1'b0;
    logic       rd_n;
    logic       wr_n;
    logic       done;

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    // Behavioural reference state.
    int m_rem = 0;
    bit m_rd = 1'b1;
    bit m_wr = 1'b1;
    bit m_done = 1'b0;
    int m_len;

    always #4 clk = ~clk;

    hb_strobe_timer u_hb_strobe_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .is_write_i     (is_wr),
        .burst_i        (burst),
        .cs_timing_en_i (en),
        .rd_ws_i        (rd_ws),
        .wr_ws_i        (wr_ws),
        .rd_trim_i      (rd_trim),
        .wr_trim_i      (wr_trim),
        .rd_n_o         (rd_n),
        .wr_n_o         (wr_n),
        .done_o         (done)
    );

    // Reference model: remaining active clocks, updated on every edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_rd = 1'b1; m_wr = 1'b1; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_rem > 0) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    m_rd = 1'b1; m_wr = 1'b1; m_done = 1'b1;
                end
            end else if (start) begin
                if (en && !burst) m_len = 2 * (is_wr ? wr_ws : rd_ws) + 2;
                else              m_len = 2;
                if (is_wr ? wr_trim : rd_trim) m_len = m_len - 1;
                m_rem = m_len;
                if (is_wr) m_wr = 1'b0; else m_rd = 1'b0;
            end
        end
    end

    task automatic check_now();
        checks++;
        if (rd_n !== m_rd || wr_n !== m_wr) begin
            errors++;
            $display("FAIL %s: rd_n=%b wr_n=%b expected rd_n=%b wr_n=%b at %0t",
                     tag, rd_n, wr_n, m_rd, m_wr, $time);
        end
        checks++;
        if (done !== m_done) begin
            errors++;
            $display("FAIL R9 (%s): done=%b expected %b at %0t", tag, done, m_done, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic access(bit wr, int idle);
        start = 1'b1; is_wr = wr;
        cyc(1);
        start = 1'b0;
        cyc(idle);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R2 R3: read lengths for every code
        tag = "R2 R3";
        for (int c = 0; c < 4; c++) begin
            rd_ws = 2'(c);
            access(1'b0, 11);
        end

        // R2 R4: write lengths for every code
        tag = "R2 R4";
        for (int c = 0; c < 4; c++) begin
            wr_ws = 2'(c);
            access(1'b1, 11);
        end

        // R5: trims, including the minimum 1-clock strobe
        tag = "R5";
        rd_ws = 2'd2; rd_trim = 1'b1;
        access(1'b0, 9);
        wr_ws = 2'd0; wr_trim = 1'b1;
        access(1'b1, 4);
        wr_ws = 2'd3;
        access(1'b1, 10);
        rd_trim = 1'b0;
        access(1'b1, 10);
        wr_trim = 1'b0; rd_trim = 1'b1;
        access(1'b1, 10);
        rd_trim = 1'b0;

        // R6: burst ignores codes
        tag = "R6";
        burst = 1'b1; rd_ws = 2'd3; wr_ws = 2'd3;
        access(1'b0, 4);
        access(1'b1, 4);
        rd_trim = 1'b1;
        access(1'b0, 4);
        rd_trim = 1'b0; burst = 1'b0;

        // R7: timing enable off ignores codes
        tag = "R7";
        en = 1'b0;
        access(1'b0, 4);
        wr_trim = 1'b1;
        access(1'b1, 4);
        wr_trim = 1'b0; en = 1'b1;

        // R8: configuration changed mid-access
        tag = "R8";
        rd_ws = 2'd3;
        start = 1'b1; is_wr = 1'b0;
        cyc(1);
        start = 1'b0;
        cyc(1);
        rd_ws = 2'd0; rd_trim = 1'b1; burst = 1'b1; en = 1'b0; is_wr = 1'b1;
        cyc(12);
        rd_trim = 1'b0; burst = 1'b0; en = 1'b1;

        // R10 R11: start held high across accesses
        tag = "R10 R11";
        wr_ws = 2'd1; is_wr = 1'b1; start = 1'b1;
        cyc(20);
        is_wr = 1'b0; rd_ws = 2'd0;
        cyc(9);
        start = 1'b0;
        cyc(6);

        // R1: reset in the middle of an access
        tag = "R1";
        rd_ws = 2'd3;
        access(1'b0, 2);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule